// File: doc/BRIEF.md
# Indexed VGA Register Port Decoder

This block sits between a byte-wide host I/O bus and the VGA-compatible register file of a display controller. The host issues 8-bit reads and writes at 16-bit I/O addresses. The block sends each access to the index latch or to the selected entry of one of four indexed banks: CRT controller, sequencer, graphics controller and attribute controller. It also serves a single miscellaneous output register. Every bank keeps its own storage. A read returns data in the same cycle, and a write takes effect at the next clock edge.

The attribute controller has only one write address. An internal phase bit decides whether a write at that address is taken as an index or as data. Reading the input-status address puts the phase back to index. The block also contains a palette loader. A host writes a starting entry, then writes colour bytes in red, green, blue order. Each completed triple is committed to the palette storage, and the entry pointer then moves to the next entry. The display path reads the palette through a separate combinational lookup port.

Top module: `vga_port_dec`

## Requirements
- R1: After reset the miscellaneous register reads 0xEB. Attribute entries 0 to 15 hold their own index number. All other bank entries, all index latches, the palette pointer and every palette entry are zero, and the attribute phase is index.
- R2: A write to 0x3D4 sets the CRT index, which reads back at 0x3D4. Reads and writes at 0x3D5 reach the CRT entry that the index selects. The CRT index changes only on a 0x3D4 write.
- R3: The sequencer index is at 0x3C4 and its data at 0x3C5. The sequencer has SEQ_N entries, 5 by default.
- R4: The graphics controller index is at 0x3CE and its data at 0x3CF. It has GFX_N entries, 9 by default.
- R5: Each write to 0x3C0 flips the attribute phase. In the index phase the byte becomes the attribute index. In the data phase it is stored in the indexed entry. The index reads back at 0x3C0 and the selected entry at 0x3C1. There are ATTR_N entries, 21 by default.
- R6: A read of 0x3DA returns 0x00 and sets the attribute phase to index, so the next 0x3C0 write is an index.
- R7: The miscellaneous register is written at 0x3C2 and read at 0x3CC. A write to 0x3CC leaves it unchanged, and a read of 0x3C2 returns 0x00.
- R8: When an index is at or beyond the bank size, a data read returns 0x00 and a data write changes no entry.
- R9: A write to 0x3C8 sets the palette pointer. Three writes to 0x3C9 then carry red, green and blue. The entry is committed only after the blue byte. pix_rgb shows {red, green, blue} in bits 23:16, 15:8 and 7:0.
- R10: After each commit the pointer advances by one and wraps from PAL_N-1 to 0. A read of 0x3C8 returns the current pointer.
- R11: A 0x3C8 write in the middle of a colour triple discards the partial triple, and the next 0x3C9 byte is taken as red.
- R12: A read of any unmapped address returns 0x00. io_rdata is 0x00 whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd |
| pix_idx | input | PW | Palette lookup entry for the display path |
| pix_rgb | output | 24 | Palette lookup result {red, green, blue} |

## Verification
The bench builds the block with PAL_N = 16 and CRT_N = 25; the other parameters keep their default values. A 16-entry palette brings the wrap of the pointer from 15 back to 0 within a few writes. A 25-entry CRT bank puts out-of-range indexes close to the used ones, so one test sequence covers in-range and out-of-range accesses in the CRT, sequencer, graphics and attribute banks. The 21-entry attribute bank still contains the index-numbered reset entries that the bench checks after reset.

// File: rtl/vga_io_pkg.sv
package vga_io_pkg;
    localparam int IO_AW = 16;
    localparam int DW    = 8;

    localparam logic [IO_AW-1:0] A_ATTR_W = 16'h03C0;
    localparam logic [IO_AW-1:0] A_ATTR_R = 16'h03C1;
    localparam logic [IO_AW-1:0] A_MISC_W = 16'h03C2;
    localparam logic [IO_AW-1:0] A_SEQ_I  = 16'h03C4;
    localparam logic [IO_AW-1:0] A_SEQ_D  = 16'h03C5;
    localparam logic [IO_AW-1:0] A_PAL_I  = 16'h03C8;
    localparam logic [IO_AW-1:0] A_PAL_D  = 16'h03C9;
    localparam logic [IO_AW-1:0] A_MISC_R = 16'h03CC;
    localparam logic [IO_AW-1:0] A_GFX_I  = 16'h03CE;
    localparam logic [IO_AW-1:0] A_GFX_D  = 16'h03CF;
    localparam logic [IO_AW-1:0] A_CRT_I  = 16'h03D4;
    localparam logic [IO_AW-1:0] A_CRT_D  = 16'h03D5;
    localparam logic [IO_AW-1:0] A_STAT   = 16'h03DA;

    localparam logic [DW-1:0] MISC_RST = 8'hEB;
    localparam int IDENT_N = 16;

    typedef struct packed {
        logic [DW-1:0] r;
        logic [DW-1:0] g;
        logic [DW-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} pal_phase_e;
    typedef enum logic {AT_INDEX = 1'b0, AT_DATA = 1'b1} attr_phase_e;
    typedef enum logic {RST_ZERO = 1'b0, RST_IDENT = 1'b1} bank_rst_e;
endpackage

// File: rtl/vga_idx_bank.sv
module vga_idx_bank
    import vga_io_pkg::*;
#(
    parameter int        N   = 8,
    parameter bank_rst_e RST = RST_ZERO
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_we,
    input  logic          dat_we,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] idx_q,
    output logic [DW-1:0] dat_q
);
    typedef struct packed {
        logic [DW-1:0]         idx;
        logic [N-1:0][DW-1:0]  regs;
    } bank_st_t;

    bank_st_t s_d, s_q;

    function automatic bank_st_t reset_state();
        bank_st_t v;
        v.idx = '0;
        for (int i = 0; i < N; i++) begin
            v.regs[i] = (RST == RST_IDENT && i < IDENT_N) ? DW'(i) : '0;
        end
        return v;
    endfunction

    always_comb begin
        s_d = s_q;
        if (idx_we) begin
            s_d.idx = din;
        end else if (dat_we) begin
            for (int i = 0; i < N; i++) begin
                if (s_q.idx == DW'(i)) s_d.regs[i] = din;
            end
        end
    end

    always_comb begin
        dat_q = '0;
        for (int i = 0; i < N; i++) begin
            if (s_q.idx == DW'(i)) dat_q = s_q.regs[i];
        end
    end

    assign idx_q = s_q.idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end
endmodule

// File: rtl/vga_pal_wr.sv
module vga_pal_wr
    import vga_io_pkg::*;
#(
    parameter int PAL_N = 256,
    localparam int PW   = (PAL_N > 1) ? $clog2(PAL_N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_we,
    input  logic          dat_we,
    input  logic [DW-1:0] din,
    input  logic [PW-1:0] pix_idx,
    output logic [PW-1:0] ptr,
    output rgb_t          pix_rgb
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        pal_phase_e    phase;
        logic [DW-1:0] red;
        logic [DW-1:0] grn;
    } pal_st_t;

    pal_st_t c_d, c_q;
    logic    mem_we;
    rgb_t    mem_wd;
    rgb_t    mem_q [PAL_N];

    always_comb begin
        c_d    = c_q;
        mem_we = 1'b0;
        mem_wd = '0;
        if (ptr_we) begin
            c_d.ptr   = din[PW-1:0];
            c_d.phase = PH_RED;
        end else if (dat_we) begin
            case (c_q.phase)
                PH_RED: begin
                    c_d.red   = din;
                    c_d.phase = PH_GRN;
                end
                PH_GRN: begin
                    c_d.grn   = din;
                    c_d.phase = PH_BLU;
                end
                default: begin
                    mem_we    = 1'b1;
                    mem_wd    = '{r: c_q.red, g: c_q.grn, b: din};
                    c_d.ptr   = (c_q.ptr == PW'(PAL_N - 1)) ? '0 : c_q.ptr + 1'b1;
                    c_d.phase = PH_RED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ptr: '0, phase: PH_RED, red: '0, grn: '0};
        else        c_q <= c_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAL_N; i++) mem_q[i] <= '0;
        end else if (mem_we) begin
            for (int i = 0; i < PAL_N; i++) begin
                if (c_q.ptr == PW'(i)) mem_q[i] <= mem_wd;
            end
        end
    end

    always_comb begin
        pix_rgb = '0;
        for (int i = 0; i < PAL_N; i++) begin
            if (pix_idx == PW'(i)) pix_rgb = mem_q[i];
        end
    end

    assign ptr = c_q.ptr;
endmodule

// File: rtl/vga_port_dec.sv
module vga_port_dec
    import vga_io_pkg::*;
#(
    parameter int CRT_N  = 64,
    parameter int SEQ_N  = 5,
    parameter int GFX_N  = 9,
    parameter int ATTR_N = 21,
    parameter int PAL_N  = 256,
    localparam int PW    = (PAL_N > 1) ? $clog2(PAL_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      io_addr,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    input  logic             io_rd,
    output logic [7:0]       io_rdata,
    input  logic [PW-1:0]    pix_idx,
    output logic [23:0]      pix_rgb
);
    typedef struct packed {
        attr_phase_e   attr_ph;
        logic [DW-1:0] misc;
    } top_st_t;

    top_st_t s_d, s_q;

    logic crt_iw, crt_dw, seq_iw, seq_dw, gfx_iw, gfx_dw, at_iw, at_dw;
    logic pal_iw, pal_dw;
    logic [DW-1:0] crt_idx, crt_dat, seq_idx, seq_dat;
    logic [DW-1:0] gfx_idx, gfx_dat, at_idx, at_dat;
    logic [PW-1:0] pal_ptr;
    rgb_t          pal_rgb;

    always_comb begin
        s_d    = s_q;
        crt_iw = io_wr && (io_addr == A_CRT_I);
        crt_dw = io_wr && (io_addr == A_CRT_D);
        seq_iw = io_wr && (io_addr == A_SEQ_I);
        seq_dw = io_wr && (io_addr == A_SEQ_D);
        gfx_iw = io_wr && (io_addr == A_GFX_I);
        gfx_dw = io_wr && (io_addr == A_GFX_D);
        pal_iw = io_wr && (io_addr == A_PAL_I);
        pal_dw = io_wr && (io_addr == A_PAL_D);
        at_iw  = 1'b0;
        at_dw  = 1'b0;
        if (io_wr && (io_addr == A_ATTR_W)) begin
            if (s_q.attr_ph == AT_INDEX) begin
                at_iw       = 1'b1;
                s_d.attr_ph = AT_DATA;
            end else begin
                at_dw       = 1'b1;
                s_d.attr_ph = AT_INDEX;
            end
        end
        if (io_rd && (io_addr == A_STAT)) s_d.attr_ph = AT_INDEX;
        if (io_wr && (io_addr == A_MISC_W)) s_d.misc = io_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{attr_ph: AT_INDEX, misc: MISC_RST};
        else        s_q <= s_d;
    end

    vga_idx_bank #(.N(CRT_N), .RST(RST_ZERO)) u_crt (
        .clk(clk), .rst_n(rst_n), .idx_we(crt_iw), .dat_we(crt_dw),
        .din(io_wdata), .idx_q(crt_idx), .dat_q(crt_dat));

    vga_idx_bank #(.N(SEQ_N), .RST(RST_ZERO)) u_seq (
        .clk(clk), .rst_n(rst_n), .idx_we(seq_iw), .dat_we(seq_dw),
        .din(io_wdata), .idx_q(seq_idx), .dat_q(seq_dat));

    vga_idx_bank #(.N(GFX_N), .RST(RST_ZERO)) u_gfx (
        .clk(clk), .rst_n(rst_n), .idx_we(gfx_iw), .dat_we(gfx_dw),
        .din(io_wdata), .idx_q(gfx_idx), .dat_q(gfx_dat));

    vga_idx_bank #(.N(ATTR_N), .RST(RST_IDENT)) u_attr (
        .clk(clk), .rst_n(rst_n), .idx_we(at_iw), .dat_we(at_dw),
        .din(io_wdata), .idx_q(at_idx), .dat_q(at_dat));

    vga_pal_wr #(.PAL_N(PAL_N)) u_pal (
        .clk(clk), .rst_n(rst_n), .ptr_we(pal_iw), .dat_we(pal_dw),
        .din(io_wdata), .pix_idx(pix_idx), .ptr(pal_ptr), .pix_rgb(pal_rgb));

    assign pix_rgb = pal_rgb;

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (io_addr)
                A_CRT_I:  io_rdata = crt_idx;
                A_CRT_D:  io_rdata = crt_dat;
                A_SEQ_I:  io_rdata = seq_idx;
                A_SEQ_D:  io_rdata = seq_dat;
                A_GFX_I:  io_rdata = gfx_idx;
                A_GFX_D:  io_rdata = gfx_dat;
                A_ATTR_W: io_rdata = at_idx;
                A_ATTR_R: io_rdata = at_dat;
                A_MISC_R: io_rdata = s_q.misc;
                A_PAL_I:  io_rdata = DW'(pal_ptr);
                default:  io_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vga_port_dec_chk.sv
module vga_port_dec_chk
    import vga_io_pkg::*;
#(
    parameter int PAL_N = 256,
    parameter int PW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   io_addr,
    input logic          io_wr,
    input logic          io_rd,
    input logic          attr_ph,
    input logic [7:0]    misc,
    input logic [7:0]    crt_idx,
    input logic [PW-1:0] pal_ptr,
    input logic [1:0]    pal_phase
);
    p_attr_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == A_ATTR_W) |=> (attr_ph != $past(attr_ph)));

    p_attr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == A_STAT) |=> (attr_ph == 1'b0));

    p_misc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == A_MISC_W) |=> $stable(misc));

    p_crt_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == A_CRT_I) |=> $stable(crt_idx));

    p_pal_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == A_PAL_D && pal_phase == 2'(PH_BLU)) |=>
        (pal_ptr == (($past(pal_ptr) == PW'(PAL_N - 1)) ? '0 : PW'($past(pal_ptr) + 1'b1))));
endmodule

bind vga_port_dec vga_port_dec_chk #(.PAL_N(PAL_N), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .attr_ph(s_q.attr_ph), .misc(s_q.misc), .crt_idx(crt_idx),
    .pal_ptr(pal_ptr), .pal_phase(u_pal.c_q.phase));

// File: tb/vga_port_dec_tb.sv
module vga_port_dec_tb;
    localparam int PAL_N = 16;
    localparam int PW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [PW-1:0] pix_idx = '0;
    logic [23:0] pix_rgb;
    logic        chk_pix = 1'b0;
    logic        chk_idle = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int          kind;
        logic [23:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    vga_port_dec #(.CRT_N(25), .PAL_N(PAL_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb));

    task automatic slot();
        @(posedge clk);
        #1;
        io_wr = 1'b0; io_rd = 1'b0; chk_pix = 1'b0; chk_idle = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        slot();
        io_wr = 1'b1; io_addr = a; io_wdata = d;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        item_t it;
        slot();
        io_rd = 1'b1; io_addr = a;
        it.kind = 0; it.exp = {16'h0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic pix(input logic [PW-1:0] i, input logic [23:0] e, input string tag);
        item_t it;
        slot();
        chk_pix = 1'b1; pix_idx = i;
        it.kind = 1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle_chk(input logic [15:0] a, input string tag);
        item_t it;
        slot();
        chk_idle = 1'b1; io_addr = a;
        it.kind = 2; it.exp = '0; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(negedge clk) begin
        if (rst_n && (io_rd || chk_pix || chk_idle)) begin
            item_t it;
            logic [23:0] act;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", io_rdata);
            end else begin
                it  = sb_q.pop_front();
                act = (it.kind == 1) ? pix_rgb : {16'h0, io_rdata};
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(16'h03CC, 8'hEB, "R1 misc reset");
        rd(16'h03D4, 8'h00, "R1 crt index reset");
        rd(16'h03D5, 8'h00, "R1 crt entry reset");
        rd(16'h03C8, 8'h00, "R1 palette pointer reset");
        pix(4'd9, 24'h0, "R1 palette entry reset");
        wr(16'h03C0, 8'h05);
        rd(16'h03C1, 8'h05, "R1 attr entry 5 holds its index");
        rd(16'h03DA, 8'h00, "R6 status read");

        // R2 CRT
        wr(16'h03D4, 8'h11); wr(16'h03D5, 8'hA5);
        rd(16'h03D4, 8'h11, "R2 crt index readback");
        rd(16'h03D5, 8'hA5, "R2 crt data");
        wr(16'h03D4, 8'h03); wr(16'h03D5, 8'h3C);
        rd(16'h03D5, 8'h3C, "R2 crt second entry");
        wr(16'h03D4, 8'h11);
        rd(16'h03D5, 8'hA5, "R2 crt first entry kept");

        // R3 sequencer
        wr(16'h03C4, 8'h04); wr(16'h03C5, 8'h77);
        rd(16'h03C5, 8'h77, "R3 seq last entry");
        wr(16'h03C4, 8'h01);
        rd(16'h03C5, 8'h00, "R3 seq other entry");
        rd(16'h03C4, 8'h01, "R3 seq index readback");

        // R4 graphics
        wr(16'h03CE, 8'h08); wr(16'h03CF, 8'hFF);
        rd(16'h03CF, 8'hFF, "R4 gfx last entry");
        wr(16'h03CE, 8'h00); wr(16'h03CF, 8'h12);
        rd(16'h03CF, 8'h12, "R4 gfx entry 0");
        wr(16'h03CE, 8'h08);
        rd(16'h03CF, 8'hFF, "R4 gfx entry 8 kept");

        // R8 out of range
        wr(16'h03C4, 8'h05); wr(16'h03C5, 8'h99);
        rd(16'h03C5, 8'h00, "R8 seq index 5 reads zero");
        wr(16'h03C4, 8'h04);
        rd(16'h03C5, 8'h77, "R8 seq entry 4 untouched");
        wr(16'h03C4, 8'h00);
        rd(16'h03C5, 8'h00, "R8 seq entry 0 untouched");
        wr(16'h03D4, 8'h19); wr(16'h03D5, 8'h55);
        rd(16'h03D5, 8'h00, "R8 crt index 25 reads zero");
        wr(16'h03CE, 8'h09);
        rd(16'h03CF, 8'h00, "R8 gfx index 9 reads zero");

        // R5 attribute toggle
        rd(16'h03DA, 8'h00, "R6 status read before attr");
        wr(16'h03C0, 8'h14); wr(16'h03C0, 8'h6B);
        rd(16'h03C0, 8'h14, "R5 attr index readback");
        rd(16'h03C1, 8'h6B, "R5 attr entry 20");
        wr(16'h03C0, 8'h02); wr(16'h03C0, 8'h0E);
        rd(16'h03C1, 8'h0E, "R5 attr entry 2");
        wr(16'h03C0, 8'h15); wr(16'h03C0, 8'h44);
        rd(16'h03C1, 8'h00, "R8 attr index 21 reads zero");

        // R6 status read resets the phase
        wr(16'h03C0, 8'h03);
        rd(16'h03DA, 8'h00, "R6 status mid sequence");
        wr(16'h03C0, 8'h07); wr(16'h03C0, 8'h5A);
        rd(16'h03C0, 8'h07, "R6 write after status is index");
        rd(16'h03C1, 8'h5A, "R6 following write is data");
        wr(16'h03C0, 8'h03);
        rd(16'h03C1, 8'h03, "R6 entry 3 not written");
        rd(16'h03DA, 8'h00, "R6 status");

        // R7 misc
        wr(16'h03C2, 8'h67);
        rd(16'h03CC, 8'h67, "R7 misc write");
        wr(16'h03CC, 8'h00);
        rd(16'h03CC, 8'h67, "R7 write at read address ignored");
        rd(16'h03C2, 8'h00, "R7 read at write address");

        // R9 palette
        wr(16'h03C8, 8'h02); wr(16'h03C9, 8'h10); wr(16'h03C9, 8'h20);
        pix(4'd2, 24'h0, "R9 no commit before blue");
        wr(16'h03C9, 8'h30);
        pix(4'd2, 24'h102030, "R9 entry after blue");

        // R10 auto-increment and wrap
        rd(16'h03C8, 8'h03, "R10 pointer advanced");
        wr(16'h03C9, 8'h40); wr(16'h03C9, 8'h50); wr(16'h03C9, 8'h60);
        pix(4'd3, 24'h405060, "R10 next entry");
        rd(16'h03C8, 8'h04, "R10 pointer advanced again");
        wr(16'h03C8, 8'h0F); wr(16'h03C9, 8'h01); wr(16'h03C9, 8'h02); wr(16'h03C9, 8'h03);
        pix(4'd15, 24'h010203, "R10 last entry");
        rd(16'h03C8, 8'h00, "R10 pointer wraps");

        // R11 abandoned triple
        wr(16'h03C8, 8'h06); wr(16'h03C9, 8'hAA);
        wr(16'h03C8, 8'h07); wr(16'h03C9, 8'h11); wr(16'h03C9, 8'h22); wr(16'h03C9, 8'h33);
        pix(4'd7, 24'h112233, "R11 restart at red");
        pix(4'd6, 24'h000000, "R11 abandoned entry unchanged");

        // R12 unmapped and idle
        rd(16'h03B4, 8'h00, "R12 unmapped read");
        rd(16'h03D0, 8'h00, "R12 unmapped read near crt");
        idle_chk(16'h03CC, "R12 no read strobe");

        slot();
        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb_q.size());
        end
        summary();
        $finish;
    end
endmodule